// File: doc/BRIEF.md
# DMA command queue with tags

This block sits between an accelerator core and the system bus. The core hands it transfer commands over a simple valid/stall command port. Each command names a local-store address, an external memory address, a byte length, a direction and a 5-bit tag group. Accepted commands wait in an in-order queue while the core keeps running. An issue engine takes them one at a time and cuts each transfer into 128-byte bus units. Each unit goes out on a request/acknowledge bus port, and only one unit is outstanding at any time.

Completion is tracked per tag group. A counter for each of the 32 groups rises when a command of that group is accepted. It falls when the last bus unit of such a command is acknowledged. Software can read the 32-bit idle vector, or present a mask of groups and watch a single done flag. The flag is high only when every selected group has no command left, whether queued or in flight.

The issue engine has two states. `S_IDLE` holds while the queue is empty. The transition *load* leads from `S_IDLE` to `S_ISSUE` when a command is at the head of the queue; that command is removed from the queue and its unit count computed. The transition *step* keeps `S_ISSUE` on the acknowledge of a unit that is not the last one, and advances both addresses by 128. The transition *finish* returns to `S_IDLE` on the acknowledge of the last unit and retires the command's tag.

Top module: `dma_tag_queue`

## Requirements
- R1: After reset, `bus_req` and `cmd_stall` are low and every bit of `tag_idle` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `cmd_stall` is low. Up to 16 commands wait in the queue and one more may be in issue. `cmd_stall` is high while the queue holds 16. A command presented while stalled is not taken; once the sender retries it is issued exactly once.
- R3: A command of `cmd_len` bytes produces ceil(`cmd_len`/128) bus units, and a length of 0 produces one unit. The first unit carries the command's two addresses, and each later unit adds 128 to both.
- R4: `cmd_get` = 1 selects a get (external memory into local store) and 0 a put (local store out to memory). `bus_get` carries the same encoding for every unit of the command.
- R5: Commands are issued in acceptance order, and only one unit is outstanding. `bus_req` stays high with stable `bus_get`, `bus_ls_addr` and `bus_ext_addr` until an edge where `bus_ack` is high.
- R6: `tag_idle[t]` goes low the cycle after a command with tag t is accepted. It returns to 1 only after the last unit of the last outstanding command with tag t has been acknowledged. Bit t belongs to tag value t.
- R7: `wait_done` is 1 exactly when every tag t with `wait_mask[t]` = 1 is idle. A zero mask gives 1.
- R8: Acceptance never depends on bus progress. With the bus never acknowledging, commands are accepted without stall until the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_get | input | 1 | 1 = get, 0 = put |
| cmd_tag | input | 5 | Tag group of the command |
| cmd_ls_addr | input | 18 | Local-store byte address |
| cmd_ext_addr | input | 32 | External memory byte address |
| cmd_len | input | 15 | Transfer length in bytes |
| cmd_stall | output | 1 | Queue full, command not taken |
| bus_req | output | 1 | Bus unit request |
| bus_get | output | 1 | Direction of the current unit |
| bus_ls_addr | output | 18 | Local-store address of the unit |
| bus_ext_addr | output | 32 | External address of the unit |
| bus_ack | input | 1 | Unit acknowledged |
| wait_mask | input | 32 | Tag groups selected for the wait |
| tag_idle | output | 32 | Per-tag idle flags |
| wait_done | output | 1 | All selected tags idle |

## Verification
The bench goes after lengths that are not a multiple of 128, length zero and a single exact unit. A wrong rounding there would emit one unit too few or too many, and the scoreboard sees a missing or unexpected beat. It holds the bus off so the queue fills. An off-by-one in the full test would either raise the stall early, which delays an enqueue that should have gone straight in, or drop a command, which leaves a beat missing. It places two commands in one tag and a mask spanning two tags that finish at different times. A design that cleared a tag on the first completion, or combined the mask with "any" instead of "all", would report done while work is still pending.

// File: rtl/dma_tag_pkg.sv
package dma_tag_pkg;
    localparam int LS_AW      = 18;
    localparam int EA_AW      = 32;
    localparam int LEN_W      = 15;
    localparam int TAG_W      = 5;
    localparam int NUM_TAGS   = 1 << TAG_W;
    localparam int UNIT_BYTES = 128;
    localparam int UNIT_SH    = $clog2(UNIT_BYTES);
    localparam int BEAT_W     = LEN_W - UNIT_SH + 1;

    typedef struct packed {
        logic             get;
        logic [TAG_W-1:0] tag;
        logic [LS_AW-1:0] ls;
        logic [EA_AW-1:0] ea;
        logic [LEN_W-1:0] len;
    } dma_cmd_t;

    // Number of bus units for a byte length; zero length still moves one unit.
    function automatic logic [BEAT_W-1:0] beats_of(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] rounded;
        rounded = {1'b0, len} + (LEN_W+1)'(UNIT_BYTES - 1);
        if (len == '0) return BEAT_W'(1);
        return BEAT_W'(rounded >> UNIT_SH);
    endfunction
endpackage

// File: rtl/dma_cmd_fifo.sv
module dma_cmd_fifo
    import dma_tag_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  dma_cmd_t din,
    input  logic     pop,
    output dma_cmd_t dout,
    output logic     not_empty,
    output logic     full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    dma_cmd_t           mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    assign dout      = mem[rd_ptr];
    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/dma_issue_fsm.sv
module dma_issue_fsm
    import dma_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  dma_cmd_t         head,
    input  logic             head_valid,
    output logic             pop,
    output logic             bus_req,
    output logic             bus_get,
    output logic [LS_AW-1:0] bus_ls_addr,
    output logic [EA_AW-1:0] bus_ext_addr,
    input  logic             bus_ack,
    output logic             retire,
    output logic [TAG_W-1:0] retire_tag
);
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } issue_state_t;

    issue_state_t      state;
    issue_state_t      state_nx;
    logic [LS_AW-1:0]  cur_ls;
    logic [EA_AW-1:0]  cur_ea;
    logic [BEAT_W-1:0] beats_left;
    logic              cur_get;
    logic [TAG_W-1:0]  cur_tag;
    logic              last_beat;

    assign last_beat = (beats_left == BEAT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (head_valid) state_nx = S_ISSUE;             // load
            S_ISSUE: if (bus_ack && last_beat) state_nx = S_IDLE;     // finish
            default: state_nx = S_IDLE;
        endcase
    end

    // working registers of the command in issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ls     <= '0;
            cur_ea     <= '0;
            beats_left <= '0;
            cur_get    <= 1'b0;
            cur_tag    <= '0;
        end else if (state == S_IDLE && head_valid) begin
            cur_ls     <= head.ls;
            cur_ea     <= head.ea;
            beats_left <= beats_of(head.len);
            cur_get    <= head.get;
            cur_tag    <= head.tag;
        end else if (state == S_ISSUE && bus_ack) begin          // step
            cur_ls     <= cur_ls + LS_AW'(UNIT_BYTES);
            cur_ea     <= cur_ea + EA_AW'(UNIT_BYTES);
            beats_left <= beats_left - BEAT_W'(1);
        end
    end

    // outputs
    always_comb begin
        pop          = 1'b0;
        bus_req      = 1'b0;
        retire       = 1'b0;
        unique case (state)
            S_IDLE:  pop = head_valid;
            S_ISSUE: begin
                bus_req = 1'b1;
                retire  = bus_ack && last_beat;
            end
            default: ;
        endcase
        bus_get      = cur_get;
        bus_ls_addr  = cur_ls;
        bus_ext_addr = cur_ea;
        retire_tag   = cur_tag;
    end
endmodule

// File: rtl/dma_tag_counters.sv
module dma_tag_counters #(
    parameter int TAG_W = 5,
    parameter int CNT_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic [TAG_W-1:0]      inc_tag,
    input  logic                  dec,
    input  logic [TAG_W-1:0]      dec_tag,
    output logic [(1<<TAG_W)-1:0] tag_idle
);
    localparam int NT = 1 << TAG_W;

    for (genvar t = 0; t < NT; t++) begin : g_tag
        logic [CNT_W-1:0] cnt;
        logic             hit_inc;
        logic             hit_dec;

        assign hit_inc = inc && (inc_tag == TAG_W'(t));
        assign hit_dec = dec && (dec_tag == TAG_W'(t));

        always_ff @(posedge clk) begin
            if (!rst_n)                cnt <= '0;
            else if (hit_inc && !hit_dec) cnt <= cnt + CNT_W'(1);
            else if (hit_dec && !hit_inc) cnt <= cnt - CNT_W'(1);
        end

        assign tag_idle[t] = (cnt == '0);
    end
endmodule

// File: rtl/dma_tag_queue.sv
module dma_tag_queue
    import dma_tag_pkg::*;
#(
    parameter int QUEUE_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_get,
    input  logic [TAG_W-1:0]    cmd_tag,
    input  logic [LS_AW-1:0]    cmd_ls_addr,
    input  logic [EA_AW-1:0]    cmd_ext_addr,
    input  logic [LEN_W-1:0]    cmd_len,
    output logic                cmd_stall,
    output logic                bus_req,
    output logic                bus_get,
    output logic [LS_AW-1:0]    bus_ls_addr,
    output logic [EA_AW-1:0]    bus_ext_addr,
    input  logic                bus_ack,
    input  logic [NUM_TAGS-1:0] wait_mask,
    output logic [NUM_TAGS-1:0] tag_idle,
    output logic                wait_done
);
    // queue entries plus the one in issue
    localparam int CNT_W = $clog2(QUEUE_DEPTH + 2);

    dma_cmd_t         new_cmd;
    dma_cmd_t         head;
    logic             head_valid;
    logic             pop;
    logic             accept;
    logic             retire;
    logic [TAG_W-1:0] retire_tag;

    assign new_cmd = '{get: cmd_get, tag: cmd_tag, ls: cmd_ls_addr,
                       ea: cmd_ext_addr, len: cmd_len};
    assign accept  = cmd_valid && !cmd_stall;

    dma_cmd_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .din       (new_cmd),
        .pop       (pop),
        .dout      (head),
        .not_empty (head_valid),
        .full      (cmd_stall)
    );

    dma_issue_fsm u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .head         (head),
        .head_valid   (head_valid),
        .pop          (pop),
        .bus_req      (bus_req),
        .bus_get      (bus_get),
        .bus_ls_addr  (bus_ls_addr),
        .bus_ext_addr (bus_ext_addr),
        .bus_ack      (bus_ack),
        .retire       (retire),
        .retire_tag   (retire_tag)
    );

    dma_tag_counters #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (accept),
        .inc_tag  (cmd_tag),
        .dec      (retire),
        .dec_tag  (retire_tag),
        .tag_idle (tag_idle)
    );

    // "all" wait: every selected group must be idle
    assign wait_done = &(tag_idle | ~wait_mask);
endmodule

// File: rtl/dma_tag_queue_chk.sv
module dma_tag_queue_chk
    import dma_tag_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_stall,
    input logic [TAG_W-1:0]    cmd_tag,
    input logic                bus_req,
    input logic                bus_ack,
    input logic                bus_get,
    input logic [LS_AW-1:0]    bus_ls_addr,
    input logic [EA_AW-1:0]    bus_ext_addr,
    input logic [NUM_TAGS-1:0] wait_mask,
    input logic [NUM_TAGS-1:0] tag_idle,
    input logic                wait_done
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !cmd_stall && (tag_idle == '1)));

    p_stall_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_stall) |-> $past(bus_req && bus_ack, 2));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_get)
            && $stable(bus_ls_addr) && $stable(bus_ext_addr)));

    p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stall) |=> !tag_idle[$past(cmd_tag)]);

    p_idle_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tag_idle & ~$past(tag_idle)) != '0) |-> $past(bus_req && bus_ack));

    p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mask == '0) |-> wait_done);
endmodule

bind dma_tag_queue dma_tag_queue_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_stall    (cmd_stall),
    .cmd_tag      (cmd_tag),
    .bus_req      (bus_req),
    .bus_ack      (bus_ack),
    .bus_get      (bus_get),
    .bus_ls_addr  (bus_ls_addr),
    .bus_ext_addr (bus_ext_addr),
    .wait_mask    (wait_mask),
    .tag_idle     (tag_idle),
    .wait_done    (wait_done)
);

// File: tb/dma_tag_queue_tb.sv
`timescale 1ns/1ps
module dma_tag_queue_tb;
    import dma_tag_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmd_valid = 1'b0;
    logic                cmd_get = 1'b0;
    logic [TAG_W-1:0]    cmd_tag = '0;
    logic [LS_AW-1:0]    cmd_ls_addr = '0;
    logic [EA_AW-1:0]    cmd_ext_addr = '0;
    logic [LEN_W-1:0]    cmd_len = '0;
    logic                cmd_stall;
    logic                bus_req;
    logic                bus_get;
    logic [LS_AW-1:0]    bus_ls_addr;
    logic [EA_AW-1:0]    bus_ext_addr;
    logic                bus_ack = 1'b0;
    logic [NUM_TAGS-1:0] wait_mask = '1;
    logic [NUM_TAGS-1:0] tag_idle;
    logic                wait_done;

    always #2.5 clk = ~clk;

    dma_tag_queue u_dut (.*);

    typedef struct packed {
        logic             get;
        logic [LS_AW-1:0] ls;
        logic [EA_AW-1:0] ea;
    } beat_t;

    beat_t sb[$];
    beat_t exp_b;
    int    checks = 0;
    int    errors = 0;
    int    beats_done = 0;
    bit    ack_en = 1'b0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: offers a command, retries while stalled, records expected beats
    task automatic enq(input logic g, input logic [TAG_W-1:0] t,
                       input logic [LS_AW-1:0] ls, input logic [EA_AW-1:0] ea,
                       input logic [LEN_W-1:0] len, output int waited);
        int n;
        waited = 0;
        @(negedge clk);
        while (cmd_stall) begin
            waited++;
            @(negedge clk);
        end
        cmd_valid = 1'b1; cmd_get = g; cmd_tag = t;
        cmd_ls_addr = ls; cmd_ext_addr = ea; cmd_len = len;
        n = (len == '0) ? 1 : (int'(len) + 127) / 128;
        for (int k = 0; k < n; k++)
            sb.push_back('{get: g, ls: ls + LS_AW'(k * 128), ea: ea + EA_AW'(k * 128)});
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: compares each bus unit with the scoreboard, then acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) bus_ack = 1'b0;
            else if (bus_ack) bus_ack = 1'b0;
            else if (bus_req && ack_en) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected bus unit", 64'd1, 64'd0);
                end else begin
                    exp_b = sb.pop_front();
                    chk(bus_get == exp_b.get, "R4 unit direction", 64'(bus_get), 64'(exp_b.get));
                    chk(bus_ls_addr == exp_b.ls && bus_ext_addr == exp_b.ea,
                        "R3 R5 unit address/order",
                        64'({bus_ls_addr, bus_ext_addr}), 64'({exp_b.ls, exp_b.ea}));
                end
                bus_ack = 1'b1;
                beats_done++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=drained");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        int base;
        bit late_done;
        int waits_sum;
        late_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!bus_req, "R1 bus_req after reset", 64'(bus_req), 64'd0);
        chk(!cmd_stall, "R1 cmd_stall after reset", 64'(cmd_stall), 64'd0);
        chk(tag_idle == '1, "R1 tag_idle after reset", 64'(tag_idle), 64'hffffffff);
        chk(wait_done, "R7 done with all tags idle", 64'(wait_done), 64'd1);
        ack_en = 1'b1;

        // R3 R4 R6: get of 256 bytes, tag 3
        enq(1'b1, 5'd3, 18'h00100, 32'h8000_0000, 15'd256, w);
        chk(!tag_idle[3], "R6 tag 3 busy after accept", 64'(tag_idle[3]), 64'd0);
        drain();
        chk(tag_idle == '1, "R6 all idle after drain", 64'(tag_idle), 64'hffffffff);

        // R3 R4: puts with odd lengths
        base = beats_done;
        enq(1'b0, 5'd9, 18'h3ff80, 32'h0000_1f80, 15'd200, w);
        enq(1'b0, 5'd9, 18'h02000, 32'h0001_0000, 15'd0, w);
        enq(1'b1, 5'd9, 18'h04000, 32'h0002_0000, 15'd128, w);
        enq(1'b0, 5'd9, 18'h06000, 32'h0003_0000, 15'd129, w);
        drain();
        chk(beats_done - base == 6, "R3 unit count for 200/0/128/129", 64'(beats_done - base), 64'd6);

        // R7 masked wait over two tags
        ack_en = 1'b0;
        enq(1'b1, 5'd1, 18'h00000, 32'h0004_0000, 15'd128, w);
        enq(1'b1, 5'd2, 18'h01000, 32'h0005_0000, 15'd384, w);
        wait_mask = 32'h0000_0006; #1;
        chk(!wait_done, "R7 mask {1,2} pending", 64'(wait_done), 64'd0);
        wait_mask = 32'h0000_0020; #1;
        chk(wait_done, "R7 mask {5} idle", 64'(wait_done), 64'd1);
        wait_mask = 32'h0; #1;
        chk(wait_done, "R7 zero mask", 64'(wait_done), 64'd1);
        ack_en = 1'b1;
        while (!tag_idle[1]) @(negedge clk);
        #1;
        wait_mask = 32'h0000_0006; #1;
        chk(!wait_done, "R7 mask {1,2} with tag 2 running", 64'(wait_done), 64'd0);
        chk(!tag_idle[2], "R6 tag 2 still busy", 64'(tag_idle[2]), 64'd0);
        wait_mask = 32'h0000_0002; #1;
        chk(wait_done, "R7 mask {1} after tag 1 done", 64'(wait_done), 64'd1);
        drain();
        wait_mask = 32'h0000_0006; #1;
        chk(wait_done, "R7 mask {1,2} all done", 64'(wait_done), 64'd1);

        // R6 two commands on the same tag
        ack_en = 1'b0;
        base = beats_done;
        enq(1'b0, 5'd7, 18'h08000, 32'h0006_0000, 15'd128, w);
        enq(1'b1, 5'd7, 18'h09000, 32'h0007_0000, 15'd256, w);
        ack_en = 1'b1;
        while (beats_done < base + 1) @(negedge clk);
        @(negedge clk); #1;
        chk(!tag_idle[7], "R6 tag 7 busy after first of two", 64'(tag_idle[7]), 64'd0);
        drain();
        chk(tag_idle[7], "R6 tag 7 idle after both", 64'(tag_idle[7]), 64'd1);

        // R2 R8 fill with the bus held off
        ack_en = 1'b0;
        base = beats_done;
        waits_sum = 0;
        for (int i = 0; i < 17; i++) begin
            enq(1'b1, 5'(10 + i % 4), 18'(i * 256), 32'h0010_0000 + 32'(i * 4096), 15'd64, w);
            waits_sum += w;
        end
        chk(waits_sum == 0, "R8 accepts without bus progress", 64'(waits_sum), 64'd0);
        chk(cmd_stall, "R2 stall with 16 queued plus one issuing", 64'(cmd_stall), 64'd1);
        fork
            begin
                int w2;
                enq(1'b0, 5'd20, 18'h3f000, 32'hfff0_0000, 15'd300, w2);
                late_done = 1'b1;
            end
        join_none
        repeat (10) @(negedge clk);
        chk(cmd_stall, "R2 stall held while bus idle", 64'(cmd_stall), 64'd1);
        chk(sb.size() == 17, "R2 refused command not taken", 64'(sb.size()), 64'd17);
        chk(tag_idle[20], "R2 refused command leaves its tag idle", 64'(tag_idle[20]), 64'd1);
        ack_en = 1'b1;
        while (!late_done) @(negedge clk);
        drain();
        chk(beats_done - base == 20, "R2 all commands issued once", 64'(beats_done - base), 64'd20);
        chk(tag_idle == '1, "R6 all idle at end", 64'(tag_idle), 64'hffffffff);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule